// File: doc/BRIEF.md
# PS/2 Wake Isolation and PME Logic

This block sits between the keyboard and mouse PS/2 pins and an on-chip keyboard controller. Each pin passes through a two-flop synchroniser. The synchronised clock and data lines go on to the controller, unless isolation is active. Software isolation bits or a power-down input block a channel, and a blocked channel is presented to the controller at the idle-high level. The wake path always sees the real synchronised data lines, whether or not the channel is isolated.

Four wake events set sticky status bits:
- a rising edge on the keyboard controller's keyboard interrupt;
- a rising edge on the controller's mouse interrupt;
- a falling edge on the synchronised keyboard data line;
- a falling edge on the synchronised mouse data line.

The two interrupt events count only while main power is good. The two data-edge events work on standby power as well. A single PME output is raised when a set status bit has its enable bit set and the global enable is on.

The block also forms the keyboard and mouse interrupt outputs. Each channel keeps a latched copy of its raw controller interrupt. That copy is set on a rising edge of the raw interrupt and cleared by a per-channel strobe. Each output is either the latched copy alone or the raw interrupt ANDed with the latched copy, as a control bit selects.

Top module: `ps2_wake_gate`

## Requirements
- R1: When a channel is not blocked, each controller-facing line equals its pin after two clock edges of synchroniser delay.
- R2: Control register (address 0) bit 5 forces the keyboard clock and data outputs to 1. Bit 6 does the same for the mouse. Neither bit affects the other channel.
- R3: While `pwr_down` is 1, all four controller-facing lines are 1, whatever the value of the mode bit (control bit 7).
- R4: Isolation never hides data edges from the wake logic. A falling data edge on an isolated channel still sets its status bit.
- R5: Status register (address 1) bits are assigned as follows: bit 0 keyboard interrupt rise, bit 1 mouse interrupt rise, bit 2 keyboard data fall, bit 3 mouse data fall. Each bit is set on the edge after its event. Interrupt events count only while `main_pwr_ok` is 1.
- R6: A latched interrupt copy is set by a rising edge of its raw interrupt and cleared by its clear strobe. The clear strobe wins when both occur together.
- R7: Control bit 3 (keyboard) and bit 4 (mouse) select the interrupt output. 0 gives raw AND latched, and 1 gives latched only.
- R8: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: `pme_out` = OR over i of (status[i] AND enable[i]), ANDed with the global enable. The enables sit in address 2, bits 3:0, with the global enable at bit 7.
- R10: Control bits 7:5, the status and the enables are reset only by `sb_rst_n`. Control bits 4:3 and the latched interrupts are also reset by `rst_n`.
- R11: Address 3 reads as zero, and register bits with no meaning read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| sb_rst_n | input | 1 | Standby-power reset, active low |
| rst_n | input | 1 | Main-power reset, active low |
| main_pwr_ok | input | 1 | Main power present |
| pwr_down | input | 1 | Power-down request, active high |
| kb_clk_pin | input | 1 | Keyboard clock pin |
| kb_dat_pin | input | 1 | Keyboard data pin |
| ms_clk_pin | input | 1 | Mouse clock pin |
| ms_dat_pin | input | 1 | Mouse data pin |
| kbc_kb_clk | output | 1 | Keyboard clock to controller |
| kbc_kb_dat | output | 1 | Keyboard data to controller |
| kbc_ms_clk | output | 1 | Mouse clock to controller |
| kbc_ms_dat | output | 1 | Mouse data to controller |
| kbc_kb_irq | input | 1 | Raw keyboard interrupt from controller |
| kbc_ms_irq | input | 1 | Raw mouse interrupt from controller |
| kb_irq_clr | input | 1 | Clears latched keyboard interrupt |
| ms_irq_clr | input | 1 | Clears latched mouse interrupt |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| kb_irq_out | output | 1 | Final keyboard interrupt |
| ms_irq_out | output | 1 | Final mouse interrupt |
| pme_out | output | 1 | Power-management wake event |

## Verification
The assertions assume that the raw controller interrupts are synchronous to `clk` and are held low while `rst_n` is low. Without that, a spurious rise could be recorded when the reset lifts. They also assume that both resets are applied from time zero. The stimulus drives every input at the falling clock edge. It keeps the raw interrupts at 0 around every main reset, and it starts with both resets asserted, so every property begins from a known state.

// File: rtl/ps2w_pkg.sv
package ps2w_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int N_EVT  = 4;
  localparam int N_CH   = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_EN   = 2'd2;

  // control register bit positions
  localparam int B_MODE   = 7;
  localparam int B_MS_ISO = 6;
  localparam int B_KB_ISO = 5;
  localparam int B_MS_SEL = 4;
  localparam int B_KB_SEL = 3;
  // enable register global bit
  localparam int B_GEN    = 7;

  // blocked line is shown idle-high to the controller
  function automatic logic gate_line(input logic blocked, input logic line);
    return blocked | line;
  endfunction

  // interrupt output: latched only, or raw AND latched
  function automatic logic irq_pick(input logic sel_latched, input logic raw, input logic lat);
    return sel_latched ? lat : (raw & lat);
  endfunction

  function automatic logic pme_calc(input logic [N_EVT-1:0] stat, input logic [N_EVT-1:0] en,
                                    input logic glob);
    return glob & (|(stat & en));
  endfunction
endpackage

// File: rtl/ps2w_sync.sv
module ps2w_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '1;
    end else begin
      st_q[0] <= d;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/ps2w_irq_latch.sv
module ps2w_irq_latch import ps2w_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic clr,
  input  logic sel_latched,
  output logic rise,
  output logic irq_out
);
  logic prev_q, lat_q;

  assign rise = raw & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= raw;
      if (clr)       lat_q <= 1'b0;
      else if (rise) lat_q <= 1'b1;
    end
  end

  assign irq_out = irq_pick(sel_latched, raw, lat_q);

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !lat_q);
  a_r6_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (raw && !$past(raw) && !clr) |=> lat_q);
  a_r7_and_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_latched && irq_out) |-> raw);
endmodule

// File: rtl/ps2w_wake_regs.sv
module ps2w_wake_regs import ps2w_pkg::*; (
  input  logic              clk,
  input  logic              sb_rst_n,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [N_EVT-1:0]  evt,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              kb_iso,
  output logic              ms_iso,
  output logic              kb_sel,
  output logic              ms_sel,
  output logic              pme
);
  logic             mode_q, ms_iso_q, kb_iso_q;
  logic [1:0]       sel_q;       // {ms, kb}
  logic [N_EVT-1:0] stat_q, en_q, clr_v;
  logic             gen_q;
  logic             wr_ctrl, wr_stat, wr_en;

  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign wr_stat = reg_we && (reg_addr == A_STAT);
  assign wr_en   = reg_we && (reg_addr == A_EN);
  assign clr_v   = wr_stat ? reg_wdata[N_EVT-1:0] : '0;

  // standby-domain state
  always_ff @(posedge clk or negedge sb_rst_n) begin
    if (!sb_rst_n) begin
      mode_q   <= 1'b0;
      ms_iso_q <= 1'b0;
      kb_iso_q <= 1'b0;
      stat_q   <= '0;
      en_q     <= '0;
      gen_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mode_q   <= reg_wdata[B_MODE];
        ms_iso_q <= reg_wdata[B_MS_ISO];
        kb_iso_q <= reg_wdata[B_KB_ISO];
      end
      stat_q <= (stat_q & ~clr_v) | evt;
      if (wr_en) begin
        en_q  <= reg_wdata[N_EVT-1:0];
        gen_q <= reg_wdata[B_GEN];
      end
    end
  end

  // main-domain state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sel_q <= 2'b00;
    else if (wr_ctrl) sel_q <= {reg_wdata[B_MS_SEL], reg_wdata[B_KB_SEL]};
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[B_MODE]   = mode_q;
        reg_rdata[B_MS_ISO] = ms_iso_q;
        reg_rdata[B_KB_ISO] = kb_iso_q;
        reg_rdata[B_MS_SEL] = sel_q[1];
        reg_rdata[B_KB_SEL] = sel_q[0];
      end
      A_STAT: reg_rdata[N_EVT-1:0] = stat_q;
      A_EN: begin
        reg_rdata[N_EVT-1:0] = en_q;
        reg_rdata[B_GEN]     = gen_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign kb_iso = kb_iso_q;
  assign ms_iso = ms_iso_q;
  assign kb_sel = sel_q[0];
  assign ms_sel = sel_q[1];
  assign pme    = pme_calc(stat_q, en_q, gen_q);

  a_r5_event_recorded: assert property (@(posedge clk) disable iff (!sb_rst_n)
    (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!sb_rst_n)
    (($past(stat_q) & ~stat_q & ~$past(clr_v)) == '0));
  a_r9_pme_cause: assert property (@(posedge clk) disable iff (!sb_rst_n)
    $rose(pme) |-> ($past(reg_we) || ($past(evt) != '0)));
endmodule

// File: rtl/ps2_wake_gate.sv
module ps2_wake_gate import ps2w_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              sb_rst_n,
  input  logic              rst_n,
  input  logic              main_pwr_ok,
  input  logic              pwr_down,
  input  logic              kb_clk_pin,
  input  logic              kb_dat_pin,
  input  logic              ms_clk_pin,
  input  logic              ms_dat_pin,
  output logic              kbc_kb_clk,
  output logic              kbc_kb_dat,
  output logic              kbc_ms_clk,
  output logic              kbc_ms_dat,
  input  logic              kbc_kb_irq,
  input  logic              kbc_ms_irq,
  input  logic              kb_irq_clr,
  input  logic              ms_irq_clr,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              kb_irq_out,
  output logic              ms_irq_out,
  output logic              pme_out
);
  localparam int N_LINES = 2 * N_CH;

  logic [N_LINES-1:0] pins, syn;     // {ms_dat, ms_clk, kb_dat, kb_clk}
  logic [N_CH-1:0]    dat_syn, dat_prev_q, dat_fall;
  logic [N_CH-1:0]    raw_v, clr_v, sel_v, rise_v, out_v, irq_ev;
  logic [N_EVT-1:0]   evt;
  logic               kb_iso, ms_iso, kb_sel, ms_sel;
  logic               blk_kb, blk_ms;

  assign pins = {ms_dat_pin, ms_clk_pin, kb_dat_pin, kb_clk_pin};

  ps2w_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(sb_rst_n), .d(pins), .q(syn));

  // wake path: falling edge on synchronised data, never gated
  assign dat_syn = {syn[3], syn[1]};
  always_ff @(posedge clk or negedge sb_rst_n) begin
    if (!sb_rst_n) dat_prev_q <= '1;
    else           dat_prev_q <= dat_syn;
  end
  assign dat_fall = dat_prev_q & ~dat_syn;

  // controller path
  assign blk_kb = kb_iso | pwr_down;
  assign blk_ms = ms_iso | pwr_down;
  assign kbc_kb_clk = gate_line(blk_kb, syn[0]);
  assign kbc_kb_dat = gate_line(blk_kb, syn[1]);
  assign kbc_ms_clk = gate_line(blk_ms, syn[2]);
  assign kbc_ms_dat = gate_line(blk_ms, syn[3]);

  assign raw_v = {kbc_ms_irq, kbc_kb_irq};
  assign clr_v = {ms_irq_clr, kb_irq_clr};
  assign sel_v = {ms_sel, kb_sel};

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    ps2w_irq_latch u_lat (
      .clk(clk), .rst_n(rst_n), .raw(raw_v[c]), .clr(clr_v[c]),
      .sel_latched(sel_v[c]), .rise(rise_v[c]), .irq_out(out_v[c]));
  end

  assign irq_ev = rise_v & {N_CH{main_pwr_ok}};
  assign evt    = {dat_fall, irq_ev};
  assign kb_irq_out = out_v[0];
  assign ms_irq_out = out_v[1];

  ps2w_wake_regs u_regs (
    .clk(clk), .sb_rst_n(sb_rst_n), .rst_n(rst_n), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .evt(evt), .reg_rdata(reg_rdata),
    .kb_iso(kb_iso), .ms_iso(ms_iso), .kb_sel(kb_sel), .ms_sel(ms_sel), .pme(pme_out));

  a_r3_pwrdown_blocks: assert property (@(posedge clk) disable iff (!sb_rst_n)
    pwr_down |-> (kbc_kb_clk && kbc_kb_dat && kbc_ms_clk && kbc_ms_dat));
  a_r2_kb_iso_idle: assert property (@(posedge clk) disable iff (!sb_rst_n)
    kb_iso |-> (kbc_kb_clk && kbc_kb_dat));
  a_r2_ms_iso_idle: assert property (@(posedge clk) disable iff (!sb_rst_n)
    ms_iso |-> (kbc_ms_clk && kbc_ms_dat));
  a_r5_irq_needs_power: assert property (@(posedge clk) disable iff (!sb_rst_n)
    (evt[N_CH-1:0] != '0) |-> main_pwr_ok);
endmodule

// File: tb/sim_ps2_wake_gate.sv
module sim_ps2_wake_gate;
  localparam int PER = 10;

  logic clk = 1'b0;
  logic sb_rst_n = 1'b0, rst_n = 1'b0, main_pwr_ok = 1'b1, pwr_down = 1'b0;
  logic kb_clk_pin = 1'b1, kb_dat_pin = 1'b1, ms_clk_pin = 1'b1, ms_dat_pin = 1'b1;
  logic kbc_kb_clk, kbc_kb_dat, kbc_ms_clk, kbc_ms_dat;
  logic kbc_kb_irq = 1'b0, kbc_ms_irq = 1'b0, kb_irq_clr = 1'b0, ms_irq_clr = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  logic kb_irq_out, ms_irq_out, pme_out;

  int total = 0, bad = 0;
  bit done = 0;

  always #(PER/2) clk = ~clk;

  ps2_wake_gate u0 (.*);

  // ---------------- reference model ----------------
  bit [3:0] m_p1, m_p2;          // pin history, m_p2 is what the controller may see
  bit [1:0] m_dprev;             // previous synced data {ms, kb}
  bit       m_mode, m_msiso, m_kbiso, m_mssel, m_kbsel, m_gen;
  bit [3:0] m_stat, m_en;
  bit       m_kprev, m_mprev, m_klat, m_mlat;

  function automatic bit [7:0] m_read(input bit [1:0] a);
    case (a)
      2'd0: return {m_mode, m_msiso, m_kbiso, m_mssel, m_kbsel, 3'b000};
      2'd1: return {4'b0000, m_stat};
      2'd2: return {m_gen, 3'b000, m_en};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit [3:0] ev;
    bit kr, mr;
    ev = 4'b0000;
    if (sb_rst_n && rst_n) begin
      kr = kbc_kb_irq && !m_kprev;
      mr = kbc_ms_irq && !m_mprev;
      ev[0] = kr && main_pwr_ok;
      ev[1] = mr && main_pwr_ok;
    end else begin
      kr = 0; mr = 0;
    end
    if (sb_rst_n) begin
      ev[2] = m_dprev[0] && !m_p2[1];
      ev[3] = m_dprev[1] && !m_p2[3];
    end
    // main-domain
    if (!rst_n) begin
      m_kprev = 0; m_mprev = 0; m_klat = 0; m_mlat = 0; m_kbsel = 0; m_mssel = 0;
    end else begin
      m_klat = kb_irq_clr ? 1'b0 : (kr ? 1'b1 : m_klat);
      m_mlat = ms_irq_clr ? 1'b0 : (mr ? 1'b1 : m_mlat);
      m_kprev = kbc_kb_irq; m_mprev = kbc_ms_irq;
      if (reg_we && reg_addr == 2'd0) begin m_kbsel = reg_wdata[3]; m_mssel = reg_wdata[4]; end
    end
    // standby domain
    if (!sb_rst_n) begin
      m_p1 = 4'hf; m_p2 = 4'hf; m_dprev = 2'b11;
      m_mode = 0; m_msiso = 0; m_kbiso = 0; m_stat = 0; m_en = 0; m_gen = 0;
    end else begin
      if (reg_we && reg_addr == 2'd1) m_stat = m_stat & ~reg_wdata[3:0];
      m_stat = m_stat | ev;
      if (reg_we && reg_addr == 2'd0) begin
        m_mode = reg_wdata[7]; m_msiso = reg_wdata[6]; m_kbiso = reg_wdata[5];
      end
      if (reg_we && reg_addr == 2'd2) begin m_en = reg_wdata[3:0]; m_gen = reg_wdata[7]; end
      m_dprev = {m_p2[3], m_p2[1]};
      m_p2 = m_p1;
      m_p1 = {ms_dat_pin, ms_clk_pin, kb_dat_pin, kb_clk_pin};
    end
    #(PER/4);
    compare_all();
  end

  task automatic compare_all();
    bit bk, bm;
    string tk, tm;
    bk = m_kbiso || pwr_down;
    bm = m_msiso || pwr_down;
    tk = pwr_down ? "R3" : (m_kbiso ? "R2" : "R1");
    tm = pwr_down ? "R3" : (m_msiso ? "R2" : "R1");
    chk(tk, "kbc_kb_clk", kbc_kb_clk, bk | m_p2[0]);
    chk(tk, "kbc_kb_dat", kbc_kb_dat, bk | m_p2[1]);
    chk(tm, "kbc_ms_clk", kbc_ms_clk, bm | m_p2[2]);
    chk(tm, "kbc_ms_dat", kbc_ms_dat, bm | m_p2[3]);
    chk("R7", "kb_irq_out", kb_irq_out, m_kbsel ? m_klat : (kbc_kb_irq & m_klat));
    chk("R7", "ms_irq_out", ms_irq_out, m_mssel ? m_mlat : (kbc_ms_irq & m_mlat));
    chk("R9", "pme_out", pme_out, m_gen & (|(m_stat & m_en)));
    chk(reg_addr == 2'd1 ? "R5" : (reg_addr == 2'd3 ? "R11" : "R10"), "reg_rdata",
        reg_rdata, m_read(reg_addr));
  endtask

  // ---------------- directed stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input bit [1:0] a, input string req, input int exp);
    reg_addr = a; #1;
    chk(req, "read", reg_rdata, exp);
  endtask

  initial begin
    tick(4);
    sb_rst_n = 1; tick(1); rst_n = 1; tick(1);
    rd(0, "R10", 8'h00); rd(1, "R10", 8'h00); rd(2, "R10", 8'h00);
    rd(3, "R11", 8'h00);

    // R1 latency
    kb_clk_pin = 0; tick(1); #1;
    chk("R1", "kb clk after one edge", kbc_kb_clk, 1);
    tick(1); #1;
    chk("R1", "kb clk after two edges", kbc_kb_clk, 0);

    // R2 keyboard isolation, mouse unaffected; R4 wake path still live
    wr(0, 8'h20); #1;
    chk("R2", "kb clk isolated", kbc_kb_clk, 1);
    kb_dat_pin = 0; ms_clk_pin = 0; tick(4);
    chk("R2", "kb dat isolated", kbc_kb_dat, 1);
    chk("R2", "ms clk not isolated", kbc_ms_clk, 0);
    rd(1, "R4", 8'h04);

    // R8 write-one-to-clear
    wr(1, 8'h00); rd(1, "R8", 8'h04);
    wr(1, 8'h04); rd(1, "R8", 8'h00);

    // R3 power-down in both modes
    wr(0, 8'h00);
    @(negedge clk); pwr_down = 1; ms_dat_pin = 0; #1;
    chk("R3", "mode0 all idle", {kbc_kb_clk, kbc_kb_dat, kbc_ms_clk, kbc_ms_dat}, 4'hf);
    wr(0, 8'h80); tick(3); #1;
    chk("R3", "mode1 all idle", {kbc_kb_clk, kbc_kb_dat, kbc_ms_clk, kbc_ms_dat}, 4'hf);
    kb_clk_pin = 1; kb_dat_pin = 1; ms_clk_pin = 1; ms_dat_pin = 1; tick(4);
    wr(0, 8'h00); pwr_down = 0;
    wr(1, 8'h0f); rd(1, "R8", 8'h00);

    // R5 interrupt events need main power
    @(negedge clk); main_pwr_ok = 0; kbc_kb_irq = 1;
    @(negedge clk); kbc_kb_irq = 0; tick(2);
    rd(1, "R5", 8'h00);
    main_pwr_ok = 1; kbc_ms_irq = 1;
    @(negedge clk); kbc_ms_irq = 0; tick(1);
    rd(1, "R5", 8'h02);
    wr(1, 8'h0f);

    // R6 / R7 latch and selection
    @(negedge clk); kb_irq_clr = 1; ms_irq_clr = 1;
    @(negedge clk); kb_irq_clr = 0; ms_irq_clr = 0; kbc_kb_irq = 1;
    tick(1); #1;
    chk("R7", "and mode high", kb_irq_out, 1);
    kbc_kb_irq = 0; #1;
    chk("R7", "and mode follows raw", kb_irq_out, 0);
    wr(0, 8'h08); #1;
    chk("R7", "latched mode", kb_irq_out, 1);
    @(negedge clk); kb_irq_clr = 1; kbc_kb_irq = 1;
    @(negedge clk); kb_irq_clr = 0; kbc_kb_irq = 0; #1;
    chk("R6", "clear wins", kb_irq_out, 0);
    rd(1, "R5", 8'h01);

    // R9 pme needs global enable
    wr(2, 8'h01); #1; chk("R9", "no global", pme_out, 0);
    wr(2, 8'h81); #1; chk("R9", "enabled", pme_out, 1);
    wr(1, 8'h01); #1; chk("R9", "cleared", pme_out, 0);

    // R10 reset domains
    wr(0, 8'hf8);
    @(negedge clk); rst_n = 0; tick(2); rst_n = 1; tick(1);
    rd(0, "R10", 8'he0); rd(2, "R10", 8'h81);
    @(negedge clk); sb_rst_n = 0; rst_n = 0; tick(2); sb_rst_n = 1; rst_n = 1; tick(1);
    rd(0, "R10", 8'h00); rd(2, "R10", 8'h00);

    // mixed stimulus, checked against the model every cycle
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      {kb_clk_pin, kb_dat_pin, ms_clk_pin, ms_dat_pin} = 4'($urandom);
      kbc_kb_irq = 1'($urandom); kbc_ms_irq = 1'($urandom);
      kb_irq_clr = ($urandom % 8) == 0; ms_irq_clr = ($urandom % 8) == 0;
      pwr_down = ($urandom % 16) == 0;
      main_pwr_ok = ($urandom % 4) != 0;
      reg_we = ($urandom % 6) == 0;
      reg_addr = 2'($urandom); reg_wdata = 8'($urandom);
    end
    @(negedge clk); reg_we = 0;
    tick(4);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog: actual=timeout expected=finish");
        end
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule